// File: doc/BRIEF.md
# SDRAM Initialization and Refresh Sequencer

This block drives the command pins of one SDRAM rank from reset to normal operation. After reset it raises the clock enable and holds NOP for a power-up time computed from the clock frequency. It then issues one PRECHARGE ALL, a configurable number of AUTO REFRESH commands, and one LOAD MODE REGISTER. The mode register load can come before or after the refreshes. Each command is followed by a fixed number of NOP cycles, which gives the device time to settle.

The mode word is placed on the address pins. It is built from a bus-width select and a CAS-latency select, and a fast clock (above 66 MHz) forces CAS latency 3. When initialization ends, the busy flag drops. From then on the block requests an auto refresh every `ref_interval_i` clocks. A request that arrives while a previous refresh is still inside its recovery window is held and serviced as soon as that window closes. Data transfers and bank/row tracking belong to a surrounding controller.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low: cke_o is 0, cmd_o is NOP (4'b0111), addr_o and ba_o are 0, and busy_o is 1.
- R2: cke_o rises at the first clock after reset release and stays high. cmd_o holds NOP for exactly PWR_CYC = CLK_HZ x 100 us clocks (5000 at 50 MHz), counted from reset release, before the first other command.
- R3: Exactly one PRECHARGE ALL is issued during initialization. It is cmd_o = 4'b0010 with addr_o[10] = 1 and all other address bits 0. It is followed by exactly TRP_CYC NOP cycles.
- R4: Initialization issues exactly N_INIT_REF AUTO REFRESH commands (cmd_o = 4'b0001). Each is followed by exactly TRFC_CYC = ceil(100 ns x CLK_HZ) NOP cycles (5 at 50 MHz).
- R5: One LOAD MODE REGISTER (cmd_o = 4'b0000, ba_o = 0) is issued and followed by exactly TMRD_CYC NOPs. With mode_first_i = 0 it comes after the init refreshes. With mode_first_i = 1 it comes right after the precharge window and before the refreshes.
- R6: The mode word on addr_o during LOAD MODE is built as follows:
  - bits [2:0] = 3 when bus16_i = 1, otherwise 2;
  - bits [6:4] = 3 for CAS latency 3, otherwise 2;
  - bit 9 = bus16_i;
  - all other bits are 0.
  This gives 0x022, 0x032, 0x223 and 0x233.
- R7: CAS latency 3 is used when cl3_i = 1 or when CLK_HZ exceeds 66 MHz. Otherwise CAS latency 2 is used.
- R8: busy_o stays 1 until the first cycle after the NOP window of the last initialization command. After that it stays 0, including during periodic refreshes.
- R9: In normal operation the first AUTO REFRESH comes exactly ref_interval_i cycles after busy_o falls. When ref_interval_i > TRFC_CYC, consecutive refreshes are exactly ref_interval_i cycles apart.
- R10: A refresh request that arrives during the TRFC_CYC window of a running refresh is held. A new AUTO REFRESH then follows after exactly TRFC_CYC NOPs, so no pending request is dropped.
- R11: Every non-NOP command lasts exactly one cycle and is followed by a NOP.
- R12: On NOP cycles addr_o and ba_o are 0. ba_o is 0 on every command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_interval_i | input | RI_W | Normal-mode refresh period in clocks |
| bus16_i | input | 1 | 1 selects 16-bit device mode word, 0 selects 32-bit |
| cl3_i | input | 1 | Request CAS latency 3 |
| mode_first_i | input | 1 | Load mode register before the init refreshes |
| cke_o | output | 1 | SDRAM clock enable |
| cmd_o | output | 4 | {CS_n, RAS_n, CAS_n, WE_n} |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Row/mode address |
| busy_o | output | 1 | High until initialization completes |

## Verification
The assertions take `bus16_i`, `cl3_i` and `mode_first_i` to be steady from reset release until `busy_o` falls. They also take `ref_interval_i` to be nonzero and steady during normal operation. The request-hold property additionally relies on acknowledgement coming only from the sequencer. The bench changes every configuration input only while reset is asserted and keeps it fixed for the whole run. It picks intervals both above and below the refresh recovery window, so that both held requests and plain periodic pacing occur.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [3:0] {
    CMD_LMR  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_PRE, ST_TRP, ST_IREF, ST_IRFC,
    ST_LMR, ST_MRD, ST_IDLE, ST_NREF, ST_NRFC
  } seq_state_e;
endpackage

// File: rtl/sdram_seq_timer.sv
module sdram_seq_timer #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= RST_VAL;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_ref_pacer.sv
module sdram_ref_pacer #(
  parameter int unsigned RI_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [RI_W-1:0] interval_i,
  input  logic            ack_i,
  output logic            req_o
);
  logic [RI_W-1:0] cnt_q;
  logic [RI_W:0]   cnt_nxt;
  logic            tick, pend_q;

  assign cnt_nxt = {1'b0, cnt_q} + (RI_W+1)'(1);
  assign tick    = en_i && (cnt_nxt >= {1'b0, interval_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_nxt[RI_W-1:0];
  end

  // ack consumes one request; a tick landing in the same cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (ack_i) pend_q <= pend_q & tick;
    else            pend_q <= pend_q | tick;
  end

  assign req_o = pend_q | tick;

  a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o);
endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
  parameter int unsigned ADDR_W    = 13,
  parameter bit          FORCE_CL3 = 1'b0
) (
  input  logic              bus16_i,
  input  logic              cl3_i,
  output logic [ADDR_W-1:0] word_o
);
  logic use_cl3;
  assign use_cl3 = cl3_i | FORCE_CL3;

  always_comb begin
    word_o      = '0;
    word_o[2:0] = bus16_i ? 3'd3 : 3'd2;   // burst length 8 / 4
    word_o[6:4] = use_cl3 ? 3'd3 : 3'd2;   // CAS latency
    word_o[9]   = bus16_i;
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned PWR_US     = 100,
  parameter int unsigned TRFC_NS    = 100,
  parameter int unsigned TRP_CYC    = 2,
  parameter int unsigned TMRD_CYC   = 2,
  parameter int unsigned N_INIT_REF = 2,
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned BA_W       = 2,
  parameter int unsigned RI_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RI_W-1:0]   ref_interval_i,
  input  logic              bus16_i,
  input  logic              cl3_i,
  input  logic              mode_first_i,
  output logic              cke_o,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o
);
  localparam int unsigned PWR_CYC  = (CLK_HZ / 1000) * PWR_US / 1000;
  localparam int unsigned TRFC_CYC = ((CLK_HZ / 1000) * TRFC_NS + 999_999) / 1_000_000;
  localparam bit          FAST_CLK = CLK_HZ > 66_000_000;
  localparam int unsigned T_A      = (PWR_CYC > TRFC_CYC) ? PWR_CYC : TRFC_CYC;
  localparam int unsigned T_B      = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
  localparam int unsigned T_MAX    = (T_A > T_B) ? T_A : T_B;
  localparam int unsigned TW       = $clog2(T_MAX + 1);
  localparam int unsigned RC_W     = $clog2(N_INIT_REF + 1);

  seq_state_e        state_q, state_d;
  sdram_cmd_e        cmd;
  logic              t_load, t_done;
  logic [TW-1:0]     t_val;
  logic [RC_W-1:0]   ref_cnt_q;
  logic              ref_inc, lmr_set, lmr_done_q;
  logic              ready_q, cke_q;
  logic              ref_req, ref_ack;
  logic [ADDR_W-1:0] mode_word;

  sdram_seq_timer #(
    .W       (TW),
    .RST_VAL (TW'(PWR_CYC - 1))
  ) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .done_o (t_done)
  );

  sdram_ref_pacer #(.RI_W(RI_W)) i_pacer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ready_q),
    .interval_i (ref_interval_i),
    .ack_i      (ref_ack),
    .req_o      (ref_req)
  );

  sdram_mode_word #(.ADDR_W(ADDR_W), .FORCE_CL3(FAST_CLK)) i_mode (
    .bus16_i (bus16_i),
    .cl3_i   (cl3_i),
    .word_o  (mode_word)
  );

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    ref_inc = 1'b0;
    lmr_set = 1'b0;
    unique case (state_q)
      ST_PWR:  if (t_done) state_d = ST_PRE;
      ST_PRE: begin
        t_load  = 1'b1;
        t_val   = TW'(TRP_CYC - 1);
        state_d = ST_TRP;
      end
      ST_TRP:  if (t_done) state_d = mode_first_i ? ST_LMR : ST_IREF;
      ST_IREF: begin
        t_load  = 1'b1;
        t_val   = TW'(TRFC_CYC - 1);
        ref_inc = 1'b1;
        state_d = ST_IRFC;
      end
      ST_IRFC: if (t_done) begin
        if (ref_cnt_q == RC_W'(N_INIT_REF)) state_d = lmr_done_q ? ST_IDLE : ST_LMR;
        else                                state_d = ST_IREF;
      end
      ST_LMR: begin
        t_load  = 1'b1;
        t_val   = TW'(TMRD_CYC - 1);
        lmr_set = 1'b1;
        state_d = ST_MRD;
      end
      ST_MRD:  if (t_done) state_d = (ref_cnt_q == RC_W'(N_INIT_REF)) ? ST_IDLE : ST_IREF;
      ST_IDLE: if (ref_req) state_d = ST_NREF;
      ST_NREF: begin
        t_load  = 1'b1;
        t_val   = TW'(TRFC_CYC - 1);
        state_d = ST_NRFC;
      end
      ST_NRFC: if (t_done) state_d = ref_req ? ST_NREF : ST_IDLE;
      default: state_d = ST_PWR;
    endcase
  end

  assign ref_ack = (state_d == ST_NREF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PWR;
      ref_cnt_q  <= '0;
      lmr_done_q <= 1'b0;
      ready_q    <= 1'b0;
      cke_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      cke_q      <= 1'b1;
      if (ref_inc) ref_cnt_q <= ref_cnt_q + 1'b1;
      if (lmr_set) lmr_done_q <= 1'b1;
      if (state_d == ST_IDLE) ready_q <= 1'b1;
    end
  end

  always_comb begin
    addr_o = '0;
    unique case (state_q)
      ST_PRE:           begin cmd = CMD_PRE; addr_o[10] = 1'b1; end
      ST_IREF, ST_NREF: cmd = CMD_AREF;
      ST_LMR:           begin cmd = CMD_LMR; addr_o = mode_word; end
      default:          cmd = CMD_NOP;
    endcase
  end

  assign cmd_o  = cmd;
  assign ba_o   = '0;
  assign cke_o  = cke_q;
  assign busy_o = !ready_q;

  a_r2_cke_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);
  a_r3_pre_a10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE) |-> addr_o[10]);
  a_r8_busy_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !busy_o);
  a_r8_ready_cmds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cmd_o == CMD_NOP || cmd_o == CMD_AREF));
  a_r11_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NOP) |=> (cmd_o == CMD_NOP));
  a_r12_nop_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_NOP) |-> (addr_o == '0));
endmodule

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/1ps
module test_sdram_init_seq;
  localparam int P_CYC = 5000;  // 50 MHz x 100 us
  localparam int TRP   = 2;
  localparam int TMRD  = 2;
  localparam int TRFC  = 5;     // ceil(100 ns x 50 MHz)
  localparam int NREF  = 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

  typedef struct {
    logic [3:0]  cmd;
    int          gap;
    logic [12:0] addr;
    logic        busy;
    string       tag;
  } item_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] ival = 16'd20;
  logic        bus16 = 1'b0, cl3 = 1'b0, mfirst = 1'b0;
  logic        cke_o, busy_o;
  logic [3:0]  cmd_o;
  logic [1:0]  ba_o;
  logic [12:0] addr_o;

  item_t exp_q[$];
  int n_tests = 0, n_fail = 0;
  bit mon_en = 1'b0, first_s, busy_prev, prev_cmd, wd_expired = 1'b0;
  int gap, fall_gap, cke_bad, nop_bad, b2b;

  always #10 clk = ~clk;

  sdram_init_seq i_sdram_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .ref_interval_i(ival), .bus16_i(bus16),
    .cl3_i(cl3), .mode_first_i(mfirst), .cke_o(cke_o), .cmd_o(cmd_o),
    .ba_o(ba_o), .addr_o(addr_o), .busy_o(busy_o));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [3:0] c, input int g, input logic [12:0] a,
                      input logic b, input string t);
    item_t e;
    e.cmd = c; e.gap = g; e.addr = a; e.busy = b; e.tag = t;
    exp_q.push_back(e);
  endtask

  // monitor: pops expected commands as the design issues them
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mon_en) begin
        if (first_s) first_s = 1'b0;
        else if (!cke_o) cke_bad++;
        if (busy_prev && !busy_o && fall_gap < 0) fall_gap = gap;
        busy_prev = busy_o;
        if (cmd_o == C_NOP) begin
          if (addr_o != '0 || ba_o != '0) nop_bad++;
          gap++;
          prev_cmd = 1'b0;
        end else begin
          if (prev_cmd) b2b++;
          prev_cmd = 1'b1;
          if (ba_o != '0) nop_bad++;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected command", int'(cmd_o), int'(C_NOP));
          end else begin
            item_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (cmd_o !== e.cmd || gap != e.gap || addr_o !== e.addr || busy_o !== e.busy) begin
              n_fail++;
              $display("FAIL %s: actual cmd=%b gap=%0d addr=%h busy=%b expected cmd=%b gap=%0d addr=%h busy=%b",
                       e.tag, cmd_o, gap, addr_o, busy_o, e.cmd, e.gap, e.addr, e.busy);
            end
          end
          gap = 0;
        end
      end
    end
  end

  task automatic run_case(input logic b16, input logic c3, input logic mf,
                          input int iv, input int nnorm);
    logic [12:0] mw;
    int last_gap;
    @(negedge clk);
    rst_n = 1'b0; mon_en = 1'b0;
    bus16 = b16; cl3 = c3; mfirst = mf; ival = 16'(iv);
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk(cke_o == 1'b0 && cmd_o == C_NOP && busy_o == 1'b1 && addr_o == '0 && ba_o == '0,
        "R1", "reset state {cke,cmd,busy}", int'({cke_o, cmd_o, busy_o}), int'({1'b0, C_NOP, 1'b1}));
    mw = '0;
    mw[2:0] = b16 ? 3'd3 : 3'd2;
    mw[6:4] = c3 ? 3'd3 : 3'd2;
    mw[9]   = b16;
    push(C_PRE, P_CYC, 13'h400, 1'b1, "R2 R3");
    if (!mf) begin
      push(C_REF, TRP, '0, 1'b1, "R4");
      for (int i = 1; i < NREF; i++) push(C_REF, TRFC, '0, 1'b1, "R4");
      push(C_LMR, TRFC, mw, 1'b1, "R5 R6 R7");
      last_gap = TMRD;
    end else begin
      push(C_LMR, TRP, mw, 1'b1, "R5 R6 R7");
      push(C_REF, TMRD, '0, 1'b1, "R4");
      for (int i = 1; i < NREF; i++) push(C_REF, TRFC, '0, 1'b1, "R4");
      last_gap = TRFC;
    end
    push(C_REF, last_gap + iv, '0, 1'b0, "R9");
    for (int i = 1; i < nnorm; i++)
      push(C_REF, (iv > TRFC) ? iv - 1 : TRFC, '0, 1'b0, (iv > TRFC) ? "R9" : "R10");
    gap = 0; fall_gap = -1; cke_bad = 0; nop_bad = 0; b2b = 0;
    first_s = 1'b1; busy_prev = 1'b1; prev_cmd = 1'b0;
    rst_n = 1'b1; mon_en = 1'b1;
    while (exp_q.size() != 0 && !wd_expired) @(negedge clk);
    mon_en = 1'b0;
    chk(fall_gap == last_gap, "R8", "NOPs before busy falls", fall_gap, last_gap);
    chk(cke_bad == 0, "R2", "cycles with cke low after start", cke_bad, 0);
    chk(nop_bad == 0, "R12", "nonzero addr/ba cycles", nop_bad, 0);
    chk(b2b == 0, "R11", "back-to-back commands", b2b, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    wd_expired = 1'b1;
    n_tests++; n_fail++;
    $display("FAIL R9 watchdog: actual=hung expected=complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    run_case(1'b0, 1'b0, 1'b0, 20, 3);  // 32-bit CL2, refresh after-init spacing
    run_case(1'b1, 1'b1, 1'b1, 3, 4);   // 16-bit CL3, mode first, held requests
    run_case(1'b1, 1'b0, 1'b0, 6, 3);   // tick coincides with window end
    run_case(1'b0, 1'b1, 1'b1, 10, 3);  // 32-bit CL3, mode first
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule